// File: doc/BRIEF.md
# Oscillator Center-Period Lock Loop

This block is a slow digital control loop that keeps the average period of a free-running oscillator at a programmed target. It runs in the reference-clock domain. The oscillator output first passes through a two-flop synchronizer and a rising-edge detector. The block then counts reference cycles across a window of oscillator cycles. It compares that count with a target formed from a 9-bit offset value and moves a DAC code up or down. That code drives the analog stage that sets the oscillator's center period. A larger code means a longer period.

After reset, and after every accepted offset write, the loop runs a fixed burst of 64 fast updates. Each fast update can move the code by several steps. The loop then drops to a tracking rate 16 times slower, where each update moves the code by at most one step. This keeps the center loop well clear of any faster per-bit period modulation applied to the same oscillator.

The offset arrives over a valid/ready write channel. `wr_ready` is tied high, so the block never applies back-pressure. A beat is taken in every cycle where `wr_valid` is high, and the last beat taken wins. Each taken beat restarts the measurement window and the fast phase.

Top module: `cpl_lock`

## Requirements
- R1: While reset is active and in the first cycle after it, `dac_code` equals DAC_INIT (128), `fast_mode` is 1 and `wr_ready` is 1.
- R2: A write is taken in every cycle with `wr_valid` high (`wr_ready` stays 1). The target count becomes TGT_BASE (16) plus the 9-bit `wr_offset`.
- R3: At an update, a measured count more than 1 above the target lowers `dac_code`, and a count more than 1 below the target raises it.
- R4: At an update, a measured count within ±1 of the target leaves `dac_code` unchanged.
- R5: In fast mode, one update changes `dac_code` by min(|count − target|, FAST_STEP = 4).
- R6: In slow mode, an update happens only on every 16th completed window, and it changes `dac_code` by exactly 1.
- R7: `fast_mode` stays high for exactly 64 completed windows after reset or after a write. The window only starts at the first synchronized oscillator rising edge, so this spans about 257 oscillator rising edges.
- R8: A write taken during fast mode restarts the measurement window and the 64-update count. The cycle after the write shows `fast_mode` at 1.
- R9: `dac_code` saturates at 0 and at 255 and never wraps.
- R10: A measured count is the number of reference cycles between a synchronized oscillator rising edge and the edge WIN_CYC (4) rising edges later. With an oscillator whose count rises by one per code step, the loop settles within ±2 codes of the code whose count equals the target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_in | input | 1 | Oscillator output, asynchronous to clk |
| wr_valid | input | 1 | Offset write beat valid |
| wr_ready | output | 1 | Offset write ready, always 1 |
| wr_offset | input | 9 | Offset value carried by the write beat |
| dac_code | output | 8 | Center-period DAC code |
| fast_mode | output | 1 | 1 during the fast acquisition phase |

## Verification
The hardest condition to reach from the ports is a second write that arrives part-way through a fast phase. The check must then show that the 64-window count starts over rather than carrying on, and the only thing visible is when `fast_mode` falls. The bench models an oscillator whose period follows `dac_code` and counts its raw rising edges from each write to that fall. It issues one write 100 edges after another, so a count that was not restarted would show up as a shortfall of about 100 edges. Deadband, direction and saturation are reached by adding a bench-controlled period bias to that oscillator. This moves the loop's equilibrium without any write.

// File: rtl/cpl_pkg.sv
package cpl_pkg;
  typedef enum logic {
    MODE_SLOW = 1'b0,
    MODE_FAST = 1'b1
  } lock_mode_e;
endpackage

// File: rtl/cpl_edge_sync.sv
module cpl_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [2:0] pipe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[1:0], async_in};
  end

  assign rise = pipe_q[1] & ~pipe_q[2];
endmodule

// File: rtl/cpl_period_meter.sv
module cpl_period_meter #(
  parameter int WIN_CYC = 4,
  parameter int CNT_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             osc_rise,
  output logic             meas_vld,
  output logic [CNT_W-1:0] meas_cnt
);
  localparam int EW = $clog2(WIN_CYC) + 1;
  localparam logic [EW-1:0]    LAST_EDGE = EW'(WIN_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;

  logic             armed_q;
  logic [EW-1:0]    edge_q;
  logic [CNT_W-1:0] ref_q;
  logic [CNT_W-1:0] ref_inc;

  assign ref_inc = (ref_q == CNT_MAX) ? ref_q : ref_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      armed_q  <= 1'b0;
      edge_q   <= '0;
      ref_q    <= '0;
      meas_vld <= 1'b0;
      meas_cnt <= '0;
    end else begin
      meas_vld <= 1'b0;
      if (!armed_q) begin
        if (osc_rise) begin
          armed_q <= 1'b1;
          edge_q  <= '0;
          ref_q   <= '0;
        end
      end else if (osc_rise) begin
        if (edge_q == LAST_EDGE) begin
          meas_vld <= 1'b1;
          meas_cnt <= ref_inc;
          edge_q   <= '0;
          ref_q    <= '0;
        end else begin
          edge_q <= edge_q + 1'b1;
          ref_q  <= ref_inc;
        end
      end else begin
        ref_q <= ref_inc;
      end
    end
  end
endmodule

// File: rtl/cpl_sched.sv
module cpl_sched
  import cpl_pkg::*;
#(
  parameter int FAST_UPD = 64,
  parameter int SLOW_DIV = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       meas_vld,
  output logic       upd_en,
  output lock_mode_e mode
);
  localparam int LW = $clog2(FAST_UPD + 1);
  localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_DIV - 1);

  logic [LW-1:0] left_q;
  logic [SW-1:0] div_q;

  assign upd_en = meas_vld && !restart &&
                  ((mode == MODE_FAST) || (div_q == SLOW_LAST));

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      mode   <= MODE_FAST;
      left_q <= LW'(FAST_UPD);
      div_q  <= '0;
    end else if (meas_vld) begin
      if (mode == MODE_FAST) begin
        left_q <= left_q - 1'b1;
        div_q  <= '0;
        if (left_q == LW'(1)) mode <= MODE_SLOW;
      end else begin
        div_q <= (div_q == SLOW_LAST) ? '0 : div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cpl_dac_step.sv
module cpl_dac_step #(
  parameter int DAC_W     = 8,
  parameter int CNT_W     = 12,
  parameter int FAST_STEP = 4,
  parameter int DAC_INIT  = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic             fast,
  input  logic [CNT_W-1:0] meas_cnt,
  input  logic [CNT_W-1:0] target_cnt,
  output logic [DAC_W-1:0] code
);
  localparam logic [DAC_W-1:0] CODE_MAX = '1;
  localparam logic [CNT_W:0]   FSTEP    = (CNT_W+1)'(FAST_STEP);

  logic [CNT_W:0]   mag;
  logic             too_long;
  logic             too_short;
  logic [CNT_W:0]   step_w;
  logic [DAC_W-1:0] step;
  logic [DAC_W:0]   room_up;

  always_comb begin
    too_long  = {1'b0, meas_cnt} > ({1'b0, target_cnt} + 1'b1);
    too_short = ({1'b0, meas_cnt} + 1'b1) < {1'b0, target_cnt};
    mag       = too_long ? ({1'b0, meas_cnt} - {1'b0, target_cnt})
                         : ({1'b0, target_cnt} - {1'b0, meas_cnt});
    if (!fast)           step_w = (CNT_W+1)'(1);
    else if (mag > FSTEP) step_w = FSTEP;
    else                 step_w = mag;
    step    = DAC_W'(step_w);
    room_up = {1'b0, CODE_MAX} - {1'b0, code};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code <= DAC_W'(DAC_INIT);
    end else if (upd_en) begin
      if (too_long)
        code <= (code < step) ? '0 : code - step;
      else if (too_short)
        code <= (room_up < {1'b0, step}) ? CODE_MAX : code + step;
    end
  end
endmodule

// File: rtl/cpl_lock.sv
module cpl_lock
  import cpl_pkg::*;
#(
  parameter int DAC_W       = 8,
  parameter int OFS_W       = 9,
  parameter int CNT_W       = 12,
  parameter int WIN_CYC     = 4,
  parameter int FAST_UPD    = 64,
  parameter int SLOW_DIV    = 16,
  parameter int FAST_STEP   = 4,
  parameter int TGT_BASE    = 16,
  parameter int DAC_INIT    = 128,
  parameter int OFFSET_INIT = 132
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_in,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [OFS_W-1:0] wr_offset,
  output logic [DAC_W-1:0] dac_code,
  output logic             fast_mode
);
  logic             wr_fire;
  logic [OFS_W-1:0] offset_q;
  logic [CNT_W-1:0] target_cnt;
  logic             osc_rise;
  logic             meas_vld;
  logic [CNT_W-1:0] meas_cnt;
  logic             upd_en;
  lock_mode_e       mode;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid & wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)       offset_q <= OFS_W'(OFFSET_INIT);
    else if (wr_fire) offset_q <= wr_offset;
  end

  assign target_cnt = CNT_W'(TGT_BASE) + CNT_W'(offset_q);

  cpl_edge_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (osc_in),
    .rise     (osc_rise)
  );

  cpl_period_meter #(.WIN_CYC(WIN_CYC), .CNT_W(CNT_W)) u_meter (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (wr_fire),
    .osc_rise (osc_rise),
    .meas_vld (meas_vld),
    .meas_cnt (meas_cnt)
  );

  cpl_sched #(.FAST_UPD(FAST_UPD), .SLOW_DIV(SLOW_DIV)) u_sched (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (wr_fire),
    .meas_vld (meas_vld),
    .upd_en   (upd_en),
    .mode     (mode)
  );

  cpl_dac_step #(
    .DAC_W(DAC_W), .CNT_W(CNT_W), .FAST_STEP(FAST_STEP), .DAC_INIT(DAC_INIT)
  ) u_step (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_en     (upd_en),
    .fast       (mode == MODE_FAST),
    .meas_cnt   (meas_cnt),
    .target_cnt (target_cnt),
    .code       (dac_code)
  );

  assign fast_mode = (mode == MODE_FAST);
endmodule

// File: rtl/cpl_lock_chk.sv
module cpl_lock_chk #(
  parameter int DAC_W     = 8,
  parameter int CNT_W     = 12,
  parameter int FAST_STEP = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             fast_mode,
  input logic             upd_en,
  input logic [DAC_W-1:0] dac_code,
  input logic [CNT_W-1:0] meas_cnt,
  input logic [CNT_W-1:0] target_cnt
);
  localparam logic [DAC_W-1:0] CODE_MAX = '1;

  logic [DAC_W:0] code_x;
  logic [CNT_W:0] meas_x;
  logic [CNT_W:0] tgt_x;
  assign code_x = {1'b0, dac_code};
  assign meas_x = {1'b0, meas_cnt};
  assign tgt_x  = {1'b0, target_cnt};

  // R8
  write_enters_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> fast_mode);

  // R4
  deadband_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !wr_valid && meas_x <= tgt_x + 1'b1 && meas_x + 1'b1 >= tgt_x)
      |=> $stable(dac_code));

  // R3
  long_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && meas_x > tgt_x + 1'b1 && dac_code != '0) |=> dac_code < $past(dac_code));

  // R3
  short_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && meas_x + 1'b1 < tgt_x && dac_code != CODE_MAX) |=> dac_code > $past(dac_code));

  // R6
  slow_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !fast_mode) |=>
      (code_x + 1'b1 >= $past(code_x)) && (code_x <= $past(code_x) + 1'b1));

  // R5
  fast_step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && fast_mode) |=>
      (code_x + (DAC_W+1)'(FAST_STEP) >= $past(code_x)) &&
      (code_x <= $past(code_x) + (DAC_W+1)'(FAST_STEP)));

  // R6
  code_moves_on_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(dac_code));
endmodule

bind cpl_lock cpl_lock_chk #(
  .DAC_W(DAC_W), .CNT_W(CNT_W), .FAST_STEP(FAST_STEP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .fast_mode  (fast_mode),
  .upd_en     (upd_en),
  .dac_code   (dac_code),
  .meas_cnt   (meas_cnt),
  .target_cnt (target_cnt)
);

// File: tb/cpl_lock_test.sv
`timescale 1ns/1ps
module cpl_lock_test;
  localparam int TGT_BASE = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [8:0] wr_offset = '0;
  logic [7:0] dac_code;
  logic       fast_mode;

  int n_chk = 0;
  int n_bad = 0;
  int bias_ns = 0;
  int osc_edges = 0;
  int e0 = 0;
  int v5 = 0, v6 = 0, v6r = 0, n_chg = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cpl_lock uut (
    .clk(clk), .rst_n(rst_n), .osc_in(osc),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_offset(wr_offset),
    .dac_code(dac_code), .fast_mode(fast_mode)
  );

  // Behavioural oscillator: period = 40 + 2*code + bias ns, so a window
  // of 4 periods counts 20 + code + bias/2 reference cycles.
  initial begin
    forever begin
      real hp;
      hp = (40.0 + 2.0 * dac_code + bias_ns) / 2.0;
      osc = 1'b1;
      #(hp);
      osc = 1'b0;
      #(hp);
    end
  end

  always @(posedge osc) osc_edges++;

  function automatic int exp_code(int off, int bias);
    int c;
    c = TGT_BASE + off - 20 - bias / 2;
    if (c < 0) c = 0;
    if (c > 255) c = 255;
    return c;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Step-size and update-rate monitor.
  logic [7:0] prev_code = 8'd128;
  logic       prev_fast = 1'b1;
  int         last_edge = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (dac_code != prev_code) begin
        int d;
        d = (dac_code > prev_code) ? dac_code - prev_code : prev_code - dac_code;
        n_chg++;
        if (d > 4) v5++;
        if (!prev_fast && d != 1) v6++;
        if (!prev_fast && (osc_edges - last_edge) < 60) v6r++;
        last_edge = osc_edges;
      end
    end
    prev_code = dac_code;
    prev_fast = fast_mode;
  end

  task automatic do_write(int off);
    @(negedge clk);
    wr_valid  = 1'b1;
    wr_offset = 9'(off);
    @(posedge clk);
    e0 = osc_edges;
    @(negedge clk);
    wr_valid = 1'b0;
    chk(fast_mode == 1'b1, "R8", "fast after write", fast_mode, 1);
    chk(wr_ready == 1'b1, "R2", "ready", wr_ready, 1);
  endtask

  task automatic wait_fast_end(string req);
    int span;
    wait (fast_mode == 1'b0);
    span = osc_edges - e0;
    @(negedge clk);
    chk(span >= 255 && span <= 258, req, "edges in fast phase", span, 257);
  endtask

  task automatic chk_conv(int exp, string what);
    int d;
    d = dac_code - exp;
    chk(d >= -2 && d <= 2, "R10", what, dac_code, exp);
  endtask

  task automatic wait_osc(int n);
    repeat (n) @(posedge osc);
    @(negedge clk);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int off, c0, k0;
    void'($urandom(32'd2718));
    repeat (6) @(negedge clk);
    // R1: reset state
    chk(dac_code == 8'd128, "R1", "code in reset", dac_code, 128);
    chk(fast_mode == 1'b1, "R1", "fast in reset", fast_mode, 1);
    rst_n = 1'b1;
    e0 = osc_edges;
    @(negedge clk);
    chk(dac_code == 8'd128, "R1", "code after reset", dac_code, 128);
    chk(wr_ready == 1'b1, "R1", "ready after reset", wr_ready, 1);
    wait_fast_end("R7");
    chk_conv(exp_code(132, 0), "settle default offset");

    // R2 R7 R10: random offsets
    for (int i = 0; i < 2; i++) begin
      off = 40 + int'($urandom % 201);
      do_write(off);
      wait_fast_end("R7");
      chk_conv(exp_code(off, 0), "settle random offset");
    end

    // R8: retrigger during fast phase
    do_write(60);
    wait_osc(100);
    chk(fast_mode == 1'b1, "R8", "still fast mid-phase", fast_mode, 1);
    do_write(90);
    wait_fast_end("R8");
    chk_conv(exp_code(90, 0), "settle after retrigger");

    // R4: deadband keeps code still once settled
    k0 = n_chg;
    wait_osc(64 * 6);
    chk((n_chg - k0) <= 2, "R4", "changes while settled", n_chg - k0, 0);

    // R3: longer period lowers code in slow mode
    c0 = dac_code;
    bias_ns = 12;
    wait_osc(64 * 9);
    chk(int'(dac_code) < c0, "R3", "code lowered", dac_code, c0 - 6);
    chk_conv(exp_code(90, 12), "settle after bias");

    // R9: upper saturation
    bias_ns = 0;
    do_write(511);
    wait_fast_end("R7");
    chk(dac_code == 8'd255, "R9", "upper limit", dac_code, 255);
    wait_osc(80);
    chk(dac_code == 8'd255, "R9", "upper limit held", dac_code, 255);

    // R9: lower saturation
    bias_ns = 400;
    do_write(100);
    wait_fast_end("R7");
    chk(dac_code == 8'd0, "R9", "lower limit", dac_code, 0);
    wait_osc(80);
    chk(dac_code == 8'd0, "R9", "lower limit held", dac_code, 0);

    chk(v5 == 0, "R5", "fast steps above 4", v5, 0);
    chk(v6 == 0, "R6", "slow steps not 1", v6, 0);
    chk(v6r == 0, "R6", "slow updates too close", v6r, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule